// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block owns the program counter of a short RISC pipeline. Each cycle it presents one fetch address to a synchronous instruction memory while the instruction fetched in the previous cycle executes. The execute stage reports back three things:
- whether a branch is taken, and its target;
- whether the executing instruction is a load or store.

A taken branch does not flush the pipeline. The instruction fetched right behind the branch always executes, and the target is fetched next. That instruction is the delay slot, and a compiler may fill it with useful work or with a no-operation.

A load or store spends one extra cycle in a memory phase after execute. During that cycle the sequencer freezes fetch and sends a bubble into execute. A branch that resolves while fetch is frozen has its target parked in a pending register. The target is applied once the delay slot has been fetched.

A branch that sits in another branch's delay slot is not supported. Such a branch is ignored, and a sticky error flag is raised. The address of the executing instruction is brought out so that the executed-address trace can be observed directly.

Top module: `dslot_fetch_seq`

## Requirements
- R1: A synchronous reset sets `fetch_pc` to 0 and clears `ex_valid`, `fetch_stall` and `slot_err`. It also drops any parked redirect, so after release execution restarts at address 0, 1, 2.
- R2: With no branch and no stall, `fetch_pc` rises by one each cycle. The address in `ex_pc` (with `ex_valid` high) is the `fetch_pc` of the previous cycle.
- R3: A taken branch executing at address A with target T makes A+1 (the delay slot) execute next and T after that. A+2 is not executed.
- R4: A branch with `br_taken` low has no effect, and the instruction at A+1 and then A+2 execute.
- R5: When `ex_is_mem` is high with `ex_valid` high, `fetch_stall` is high in the next cycle. In the cycle after that, `fetch_pc` still holds its stalled value and `ex_valid` is low for exactly one cycle.
- R6: A taken branch executing while `fetch_stall` is high is kept across the stall. Its delay slot executes after the bubble, and then its target.
- R7: A taken branch executing in a delay slot is ignored, and the first branch's target follows the slot. `slot_err` goes high in the next cycle and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_taken | input | 1 | Executing instruction is a taken branch |
| br_target | input | AW | Target address of that branch |
| ex_is_mem | input | 1 | Executing instruction is a load or store |
| fetch_pc | output | AW | Address presented to instruction memory this cycle |
| fetch_stall | output | 1 | Fetch is frozen for a memory phase |
| ex_pc | output | AW | Address of the instruction in execute |
| ex_valid | output | 1 | `ex_pc` holds a real instruction (low for a bubble) |
| slot_err | output | 1 | Sticky flag: branch found in a delay slot |

## Verification
A wrong next-address choice shows in the `ex_pc` trace one cycle after the faulty fetch. A missed delay slot skips one address there, and a branch applied early or late executes the wrong address. A parked redirect that is lost or applied too soon shows as a wrong address two cycles after the stall, when the slot should execute. A stale redirect left over from before a reset shows as the second executed address after release being the old target instead of 1. Stall-tracking errors show in the very next cycle as a missing or doubled bubble or a moved `fetch_pc`.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  // Which source loads the fetch address on an advancing edge.
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,  // next sequential word
    SRC_BR   = 2'd1,  // branch resolved in execute this cycle
    SRC_PEND = 2'd2   // redirect parked across a memory-phase stall
  } redir_src_e;
endpackage

// File: rtl/dslot_next_pc.sv
module dslot_next_pc
  import dslot_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic          take,
  input  logic [AW-1:0] take_tgt,
  input  logic          pend_v,
  input  logic [AW-1:0] pend_tgt,
  output logic [AW-1:0] nxt,
  output redir_src_e    src
);
  function automatic logic [AW-1:0] pc_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  always_comb begin
    if (take) begin
      nxt = take_tgt;
      src = SRC_BR;
    end else if (pend_v) begin
      nxt = pend_tgt;
      src = SRC_PEND;
    end else begin
      nxt = pc_step(pc);
      src = SRC_SEQ;
    end
  end
endmodule

// File: rtl/dslot_ctl.sv
module dslot_ctl (
  input  logic clk,
  input  logic rst,
  input  logic ex_valid,
  input  logic ex_is_mem,
  input  logic br_taken,
  input  logic pend_v,
  output logic stall,
  output logic take_eff,
  output logic slot_bad,
  output logic slot_err
);
  logic in_slot;   // instruction now in execute is a delay slot
  logic br_seen;

  assign br_seen  = br_taken & ex_valid;
  assign take_eff = br_seen & ~in_slot;
  assign slot_bad = br_seen & in_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall    <= 1'b0;
      in_slot  <= 1'b0;
      slot_err <= 1'b0;
    end else begin
      stall    <= ex_valid & ex_is_mem;
      // The slot enters execute on the first advancing edge after the branch.
      in_slot  <= stall ? 1'b0 : (take_eff | pend_v);
      slot_err <= slot_err | slot_bad;
    end
  end

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    slot_err |=> slot_err);

  p_err_raise_r7: assert property (@(posedge clk) disable iff (rst)
    slot_bad |=> slot_err);

  p_stall_after_mem_r5: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_is_mem) |=> stall);
endmodule

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq
  import dslot_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  input  logic          ex_is_mem,
  output logic [AW-1:0] fetch_pc,
  output logic          fetch_stall,
  output logic [AW-1:0] ex_pc,
  output logic          ex_valid,
  output logic          slot_err
);
  logic          stall;
  logic          take_eff;
  logic          slot_bad;
  logic          pend_v;
  logic [AW-1:0] pend_tgt;
  logic [AW-1:0] nxt_pc;
  redir_src_e    nxt_src;

  dslot_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .ex_valid (ex_valid),
    .ex_is_mem(ex_is_mem),
    .br_taken (br_taken),
    .pend_v   (pend_v),
    .stall    (stall),
    .take_eff (take_eff),
    .slot_bad (slot_bad),
    .slot_err (slot_err)
  );

  dslot_next_pc #(.AW(AW)) u_next (
    .pc      (fetch_pc),
    .take    (take_eff),
    .take_tgt(br_target),
    .pend_v  (pend_v),
    .pend_tgt(pend_tgt),
    .nxt     (nxt_pc),
    .src     (nxt_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= RESET_PC;
      ex_pc    <= '0;
      ex_valid <= 1'b0;
      pend_v   <= 1'b0;
      pend_tgt <= '0;
    end else if (stall) begin
      // Memory phase: hold fetch, bubble into execute, park any redirect.
      ex_valid <= 1'b0;
      if (take_eff) begin
        pend_v   <= 1'b1;
        pend_tgt <= br_target;
      end
    end else begin
      ex_valid <= 1'b1;
      ex_pc    <= fetch_pc;
      fetch_pc <= nxt_pc;
      pend_v   <= 1'b0;
    end
  end

  assign fetch_stall = stall;

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall && !take_eff && !pend_v) |=> fetch_pc == $past(fetch_pc) + AW'(1));

  p_exec_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (ex_valid && ex_pc == $past(fetch_pc)));

  p_redirect_r3: assert property (@(posedge clk) disable iff (rst)
    (take_eff && !stall) |=> fetch_pc == $past(br_target));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> (fetch_pc == $past(fetch_pc) && !ex_valid));

  p_pend_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    (nxt_src == SRC_PEND) |-> !ex_valid);

  p_pend_apply_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !stall) |=> fetch_pc == $past(pend_tgt));

  p_slot_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (slot_bad && !stall && !pend_v) |=> fetch_pc == $past(fetch_pc) + AW'(1));
endmodule

// File: tb/dslot_fetch_seq_test.sv
module dslot_fetch_seq_test;
  localparam int AW = 16;
  localparam int NTR = 15;
  // kinds held in the program image
  localparam logic [1:0] K_ALU = 2'd0, K_MEM = 2'd1, K_BRT = 2'd2, K_BRN = 2'd3;
  // executed-address trace expected from the program below
  localparam int EXP [NTR] = '{0, 1, 2, 3, 5, 6, 7, 12, 13, 14, 20, 21, 22, 23, 30};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          br_taken, ex_is_mem;
  logic [AW-1:0] br_target;
  logic [AW-1:0] fetch_pc, ex_pc;
  logic          fetch_stall, ex_valid, slot_err;

  logic [1:0]    kind_mem [0:63];
  logic [AW-1:0] tgt_mem  [0:63];

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  dslot_fetch_seq #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .br_taken(br_taken), .br_target(br_target),
    .ex_is_mem(ex_is_mem), .fetch_pc(fetch_pc), .fetch_stall(fetch_stall),
    .ex_pc(ex_pc), .ex_valid(ex_valid), .slot_err(slot_err)
  );

  // Execute-stage decode of the instruction image.
  assign br_taken  = ex_valid && (kind_mem[ex_pc[5:0]] == K_BRT);
  assign ex_is_mem = ex_valid && (kind_mem[ex_pc[5:0]] == K_MEM);
  assign br_target = tgt_mem[ex_pc[5:0]];

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      kind_mem[i] = K_ALU;
      tgt_mem[i]  = '0;
    end
    kind_mem[2]  = K_BRT; tgt_mem[2]  = 16'd5;   // R3: slot 3, skip 4
    kind_mem[5]  = K_MEM;                       // R5: load
    kind_mem[6]  = K_BRT; tgt_mem[6]  = 16'd12;  // R6: branch during stall
    kind_mem[12] = K_MEM;
    kind_mem[13] = K_BRT; tgt_mem[13] = 16'd20;  // R6 again
    kind_mem[20] = K_BRN; tgt_mem[20] = 16'd0;   // R4: not taken
    kind_mem[22] = K_BRT; tgt_mem[22] = 16'd30;
    kind_mem[23] = K_BRT; tgt_mem[23] = 16'd40;  // R7: branch in slot
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int idx;
    int bubbles;
    int stalls;
    logic           chk_hold;
    logic [AW-1:0]  held_pc;
    logic           after23;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset fetch_pc", int'(fetch_pc), 0);
    chk("R1 reset ex_valid", int'(ex_valid), 0);
    chk("R1 reset fetch_stall", int'(fetch_stall), 0);
    chk("R1 reset slot_err", int'(slot_err), 0);
    rst = 1'b0;

    // Table walk: every executed address against the expected trace (R2/R3/R4/R6/R7).
    idx = 0; bubbles = 0; stalls = 0; chk_hold = 1'b0; held_pc = '0; after23 = 1'b0;
    for (int cyc = 0; cyc < 60 && idx < NTR; cyc++) begin
      @(negedge clk);
      if (after23) begin
        chk("R7 slot_err raised", int'(slot_err), 1);
        after23 = 1'b0;
      end
      if (chk_hold) begin
        chk("R5 fetch_pc held", int'(fetch_pc), int'(held_pc));
        chk("R5 bubble in execute", int'(ex_valid), 0);
        chk_hold = 1'b0;
      end
      if (fetch_stall) begin
        stalls++;
        chk_hold = 1'b1;
        held_pc  = fetch_pc;
      end
      if (ex_valid) begin
        chk("R2/R3/R4/R6/R7 trace", int'(ex_pc), EXP[idx]);
        if (EXP[idx] == 23) begin
          chk("R7 slot_err before slot branch", int'(slot_err), 0);
          after23 = 1'b1;
        end
        idx++;
      end else if (idx > 0) begin
        bubbles++;
      end
    end
    chk("R2 trace length", idx, NTR);
    chk("R5 bubble count", bubbles, 2);
    chk("R5 stall count", stalls, 2);

    // Directed: flag is sticky.
    repeat (4) @(negedge clk);
    chk("R7 slot_err sticky", int'(slot_err), 1);

    // Directed: reset while a redirect is parked (branch 13 during stall).
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      if (ex_valid && ex_pc == 16'd13 && fetch_stall) break;
    end
    @(negedge clk);  // redirect now parked
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset fetch_pc", int'(fetch_pc), 0);
    chk("R1 mid-run reset ex_valid", int'(ex_valid), 0);
    chk("R1 mid-run reset slot_err", int'(slot_err), 0);
    rst = 1'b0;
    idx = 0;
    for (int cyc = 0; cyc < 10 && idx < 3; cyc++) begin
      @(negedge clk);
      if (ex_valid) begin
        chk("R1 restart trace", int'(ex_pc), idx);
        idx++;
      end
    end
    chk("R1 restart count", idx, 3);
    summary();
  end
endmodule